// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block owns the eight-bit status byte of a serial nonvolatile memory. It also decides, once per host frame, whether a pending write may go ahead. The command decoder in front of it sends single-cycle pulses for the write-enable and write-disable commands, and pulses for the start and end of each chip-select frame. It also drives three level flags that name the kind of write being asked for in the current frame: main array, identification page or status byte. The unit compares the target address with the block-protect setting, applies the write-protect pin gating to status writes, and applies the lock and select rules of the identification page.

The decision is taken in the cycle where the frame-end pulse is sampled. It appears on the next clock as a one-cycle grant pulse for the requested kind, or as a one-cycle deny pulse. A granted status write updates the stored bits on that same edge. The write-enable latch stays set until the write engine reports completion. While an internal write cycle is busy, the unit ignores commands and frames, and the status byte stays readable with its busy bit set.

Top module: `sreg_guard`

## Requirements
- R1: After reset the status byte reads 0x00 apart from bit 0, which follows `cyc_busy`, and no grant or deny pulse is driven.
- R2: Bit 1 (write-enable latch) is set by a `cmd_wren` pulse and cleared by a `cmd_wrdi` pulse. It is also cleared by a `write_done` pulse, and `write_done` takes priority over the other two.
- R3: An array write is granted only when the latch is 1 and the address lies outside the protected range. The outcome is a one-cycle `grant_array` or `deny` pulse in the cycle after `sel_end`, and at most one of the four decision outputs is high in any cycle.
- R4: Bits 3:2 select the protected range of the 17-bit space: 00 protects no address, 01 protects addresses from 0x18000 upward, 10 protects addresses from 0x10000 upward, and 11 protects every address.
- R5: Bit layout from bit 7 down: write-protect enable, ID-page select, constant 0, ID-page lock, protect bits 1:0, write-enable latch, busy. Bit 5 always reads 0 and bit 0 equals `cyc_busy`.
- R6: A granted status write copies data bits 7, 6, 4, 3 and 2 only. When data bits 6 and 4 are both 1, bits 6 and 4 both keep their old values while bits 7, 3 and 2 still take the new data.
- R7: A status write is granted when the latch is 1, unless bit 7 is 1 and `wp_n` is low. When bit 7 is 0, the level of `wp_n` has no effect.
- R8: With bit 7 at 1, `wp_n` low in any cycle from `sel_start` through `sel_end` cancels the status write, even if the pin is high again by the end of the frame. Once the decision has been made, `wp_n` has no effect on the stored bits.
- R9: An ID-page write is granted only when the latch is 1, bit 4 is 0, bits 3:2 are not 11, and the address is outside the protected range.
- R10: Once bit 4 is 1, no status write clears it.
- R11: An `acc_end` pulse clears bit 6.
- R12: While `cyc_busy` is high, `cmd_wren` and `cmd_wrdi` have no effect and `sel_end` produces neither a grant nor a deny.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Write-enable command pulse |
| cmd_wrdi | input | 1 | Write-disable command pulse |
| sel_start | input | 1 | Frame start pulse (chip select asserted) |
| sel_end | input | 1 | Frame end pulse (chip select released) |
| req_array | input | 1 | Frame carries a main-array write |
| req_idpg | input | 1 | Frame carries an ID-page write |
| req_status | input | 1 | Frame carries a status write |
| addr | input | ADDR_W | Target byte address |
| wrsr_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin level, low active |
| cyc_busy | input | 1 | Internal write cycle in progress |
| write_done | input | 1 | Internal write cycle completed pulse |
| acc_end | input | 1 | Read or write access finished pulse |
| status_byte | output | 8 | Status byte for readback |
| grant_array | output | 1 | Array write granted pulse |
| grant_idpg | output | 1 | ID-page write granted pulse |
| grant_status | output | 1 | Status write granted pulse |
| deny | output | 1 | Requested write refused pulse |

## Verification
Array writes are tried at addresses just below and just above each range boundary, under all four protect settings. This separates an off-by-one in the boundary compare from a wrong decode of the protect bits. Status writes are tried with the pin high, held low, and dropped only briefly in mid-frame, each with the enable bit both set and clear. This tells level sampling at frame end apart from the sticky cancel. ID-page writes are tried with the lock set, with full protection, and in protected and unprotected quarters, and busy periods confirm that commands and frames are ignored.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned SR_W   = 8;
  localparam int unsigned B_WPEN = 7;
  localparam int unsigned B_IPL  = 6;
  localparam int unsigned B_LIP  = 4;
  localparam int unsigned B_WEL  = 1;
  localparam logic [SR_W-1:0] WR_MASK = 8'b1101_1100;

  typedef enum logic [1:0] {
    BP_NONE = 2'b00,
    BP_QTR  = 2'b01,
    BP_HALF = 2'b10,
    BP_ALL  = 2'b11
  } bp_e;

  // Merge a status-write data byte into the stored writable bits.
  function automatic logic [SR_W-1:0] sr_merge(input logic [SR_W-1:0] old_v,
                                               input logic [SR_W-1:0] data);
    logic [SR_W-1:0] nv;
    nv = (old_v & ~WR_MASK) | (data & WR_MASK);
    if (data[B_IPL] && data[B_LIP]) begin
      nv[B_IPL] = old_v[B_IPL];
      nv[B_LIP] = old_v[B_LIP];
    end
    nv[B_LIP] = nv[B_LIP] | old_v[B_LIP];
    return nv;
  endfunction

  // Status writes are blocked when the pin gate is enabled and the pin went low.
  function automatic logic st_gate(input logic wel, input logic wpen,
                                   input logic wp_low);
    return wel & ~(wpen & wp_low);
  endfunction
endpackage

// File: rtl/sreg_prot_dec.sv
module sreg_prot_dec
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              arr_locked,
  output logic              idp_locked
);
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

  function automatic logic in_range(input logic [1:0] sel,
                                    input logic [ADDR_W-1:0] a);
    case (bp_e'(sel))
      BP_NONE: return 1'b0;
      BP_QTR:  return a >= QTR_BASE;
      BP_HALF: return a >= HALF_BASE;
      default: return 1'b1;
    endcase
  endfunction

  assign arr_locked = in_range(bp, addr);
  assign idp_locked = in_range(bp, addr) | (bp == BP_ALL);
endmodule

// File: rtl/sreg_wp_track.sv
module sreg_wp_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_start,
  input  logic wp_n,
  output logic wp_low_seen
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= (sel_start ? 1'b0 : seen_q) | ~wp_n;
  end

  assign wp_low_seen = seen_q | ~wp_n;
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              req_array,
  input  logic              req_idpg,
  input  logic              req_status,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrsr_data,
  input  logic              wp_n,
  input  logic              cyc_busy,
  input  logic              write_done,
  input  logic              acc_end,
  output logic [7:0]        status_byte,
  output logic              grant_array,
  output logic              grant_idpg,
  output logic              grant_status,
  output logic              deny
);
  logic [SR_W-1:0] sr_q;
  logic            wel_q;
  logic            arr_locked, idp_locked, wp_low_seen;
  logic            decide, sel_st, sel_id, sel_ar;
  logic            ok_st, ok_id, ok_ar, take_st, take_id, take_ar, refuse;

  sreg_prot_dec #(.ADDR_W(ADDR_W)) i_dec (
    .bp        (sr_q[3:2]),
    .addr      (addr),
    .arr_locked(arr_locked),
    .idp_locked(idp_locked)
  );

  sreg_wp_track i_wp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_start  (sel_start),
    .wp_n       (wp_n),
    .wp_low_seen(wp_low_seen)
  );

  // One request kind per frame; status outranks ID page, ID page outranks array.
  assign decide = sel_end & ~cyc_busy;
  assign sel_st = req_status;
  assign sel_id = req_idpg & ~req_status;
  assign sel_ar = req_array & ~req_idpg & ~req_status;

  assign ok_st = st_gate(wel_q, sr_q[B_WPEN], wp_low_seen);
  assign ok_id = wel_q & ~sr_q[B_LIP] & ~idp_locked;
  assign ok_ar = wel_q & ~arr_locked;

  assign take_st = decide & sel_st & ok_st;
  assign take_id = decide & sel_id & ok_id;
  assign take_ar = decide & sel_ar & ok_ar;
  assign refuse  = decide & ((sel_st & ~ok_st) | (sel_id & ~ok_id) | (sel_ar & ~ok_ar));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q         <= '0;
      wel_q        <= 1'b0;
      grant_array  <= 1'b0;
      grant_idpg   <= 1'b0;
      grant_status <= 1'b0;
      deny         <= 1'b0;
    end else begin
      if (write_done)                 wel_q <= 1'b0;
      else if (!cyc_busy && cmd_wrdi) wel_q <= 1'b0;
      else if (!cyc_busy && cmd_wren) wel_q <= 1'b1;

      // A granted status write overrides an access-end clear in the same cycle.
      if (take_st)      sr_q <= sr_merge(sr_q, wrsr_data);
      else if (acc_end) sr_q[B_IPL] <= 1'b0;

      grant_array  <= take_ar;
      grant_idpg   <= take_id;
      grant_status <= take_st;
      deny         <= refuse;
    end
  end

  assign status_byte = sr_q | {6'b0, wel_q, cyc_busy};
endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_end,
  input logic       cyc_busy,
  input logic       write_done,
  input logic [7:0] status_byte,
  input logic       grant_array,
  input logic       grant_idpg,
  input logic       grant_status,
  input logic       deny,
  input logic       arr_locked,
  input logic       wp_low_seen
);
  a_r5_bit5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[5] == 1'b0);

  a_r3_one_decision: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_array, grant_idpg, grant_status, deny}));

  a_r3_array_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    grant_array |-> $past(status_byte[1]));

  a_r4_locked_never_granted: assert property (@(posedge clk) disable iff (!rst_n)
    grant_array |-> !$past(arr_locked));

  a_r2_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    write_done |=> !status_byte[1]);

  a_r7_status_gate: assert property (@(posedge clk) disable iff (!rst_n)
    grant_status |-> ($past(status_byte[1]) &&
                      !($past(status_byte[7]) && $past(wp_low_seen))));

  a_r9_lock_blocks_idpg: assert property (@(posedge clk) disable iff (!rst_n)
    grant_idpg |-> !$past(status_byte[4]));

  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(status_byte[4]));

  a_r12_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && sel_end) |=> !(grant_array || grant_idpg || grant_status || deny));
endmodule

bind sreg_guard sreg_guard_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_end     (sel_end),
  .cyc_busy    (cyc_busy),
  .write_done  (write_done),
  .status_byte (status_byte),
  .grant_array (grant_array),
  .grant_idpg  (grant_idpg),
  .grant_status(grant_status),
  .deny        (deny),
  .arr_locked  (arr_locked),
  .wp_low_seen (wp_low_seen)
);

// File: tb/test_sreg_guard.sv
module test_sreg_guard;
  localparam int CLK_PER = 10;
  localparam int AW = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, sel_start = 0, sel_end = 0;
  logic req_array = 0, req_idpg = 0, req_status = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wrsr_data = '0;
  logic wp_n = 1'b1, cyc_busy = 1'b0, write_done = 0, acc_end = 0;
  logic [7:0] status_byte;
  logic grant_array, grant_idpg, grant_status, deny;

  int checks = 0, errors = 0;
  bit finished = 0;

  // Bench model of the status fields
  bit m_wpen = 0, m_ipl = 0, m_lip = 0, m_wel = 0;
  bit [1:0] m_bp = 0;

  always #(CLK_PER/2) clk = ~clk;

  sreg_guard #(.ADDR_W(AW)) i_sreg_guard (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .sel_start(sel_start), .sel_end(sel_end), .req_array(req_array),
    .req_idpg(req_idpg), .req_status(req_status), .addr(addr),
    .wrsr_data(wrsr_data), .wp_n(wp_n), .cyc_busy(cyc_busy),
    .write_done(write_done), .acc_end(acc_end), .status_byte(status_byte),
    .grant_array(grant_array), .grant_idpg(grant_idpg),
    .grant_status(grant_status), .deny(deny)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit prot(input bit [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return a > 17'h17FFF;
      2'd2: return a > 17'h0FFFF;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk_status(input string tag);
    chk({tag, " status"}, {24'b0, status_byte},
        {24'b0, m_wpen, m_ipl, 1'b0, m_lip, m_bp, m_wel, cyc_busy});
  endtask

  // kind: 0 wren, 1 wrdi, 2 write_done, 3 acc_end
  task automatic pulse(input int kind);
    @(negedge clk);
    case (kind)
      0: cmd_wren = 1; 1: cmd_wrdi = 1; 2: write_done = 1; default: acc_end = 1;
    endcase
    @(negedge clk);
    {cmd_wren, cmd_wrdi, write_done, acc_end} = '0;
    case (kind)
      0: if (!cyc_busy) m_wel = 1;
      1: if (!cyc_busy) m_wel = 0;
      2: m_wel = 0;
      default: m_ipl = 0;
    endcase
  endtask

  // kind: 0 array, 1 id page, 2 status. wpm: 0 high, 1 low whole frame, 2 low mid-frame only
  task automatic req(input int kind, input logic [AW-1:0] a, input logic [7:0] d,
                     input int wpm, input string tag);
    bit ok;
    bit [3:0] exp;
    @(negedge clk);
    sel_start = 1; addr = a; wrsr_data = d;
    req_array = (kind == 0); req_idpg = (kind == 1); req_status = (kind == 2);
    wp_n = (wpm != 1);
    @(negedge clk);
    sel_start = 0;
    if (wpm == 2) wp_n = 0;
    @(negedge clk);
    if (wpm == 2) wp_n = 1;
    sel_end = 1;
    @(negedge clk);
    sel_end = 0;
    case (kind)
      0: ok = m_wel && !prot(m_bp, a);
      1: ok = m_wel && !m_lip && (m_bp != 2'd3) && !prot(m_bp, a);
      default: ok = m_wel && !(m_wpen && wpm != 0);
    endcase
    if (cyc_busy) exp = 4'b0000;
    else if (!ok) exp = 4'b0001;
    else exp = (kind == 0) ? 4'b1000 : (kind == 1) ? 4'b0100 : 4'b0010;
    chk({tag, " decision"}, {28'b0, grant_array, grant_idpg, grant_status, deny}, {28'b0, exp});
    if (!cyc_busy && ok && kind == 2) begin
      m_wpen = d[7]; m_bp = d[3:2];
      if (!(d[6] && d[4])) begin m_ipl = d[6]; m_lip = m_lip | d[4]; end
    end
    chk_status(tag);
    req_array = 0; req_idpg = 0; req_status = 0; wp_n = 1;
    @(negedge clk);
    chk({tag, " single pulse"}, {28'b0, grant_array, grant_idpg, grant_status, deny}, 32'd0);
  endtask

  // Program the status byte: enable, write, complete
  task automatic set_sr(input logic [7:0] d, input string tag);
    pulse(0); req(2, '0, d, 0, tag); pulse(2);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", {24'b0, status_byte}, 32'd0);
    chk("R1 outputs", {28'b0, grant_array, grant_idpg, grant_status, deny}, 32'd0);
  endtask

  task automatic t_wel;
    req(0, 17'h00000, 8'h00, 0, "R3 no latch");
    pulse(0); chk_status("R2 wren");
    pulse(1); chk_status("R2 wrdi");
    pulse(0); req(0, 17'h00000, 8'h00, 0, "R3 grant");
    pulse(2); chk_status("R2 done");
  endtask

  task automatic t_ranges;
    logic [AW-1:0] pts [6] = '{17'h00000, 17'h0FFFF, 17'h10000, 17'h17FFF, 17'h18000, 17'h1FFFF};
    for (int b = 0; b < 4; b++) begin
      set_sr(8'(b << 2), "R4 set bp");
      for (int i = 0; i < 6; i++) begin
        pulse(0); req(0, pts[i], 8'h00, 0, "R4 range"); pulse(2);
      end
    end
  endtask

  task automatic t_wrsr_bits;
    pulse(0); req(2, '0, 8'hFF, 0, "R6 both select and lock"); pulse(2);
    chk("R5 bit5", {31'b0, status_byte[5]}, 32'd0);
    pulse(0); req(2, '0, 8'h23, 1, "R6 masked bits"); pulse(2);
  endtask

  task automatic t_wp;
    set_sr(8'h80, "R7 enable gate");
    pulse(0);
    req(2, '0, 8'h84, 1, "R7 pin low");
    req(2, '0, 8'h84, 2, "R8 pin dipped");
    req(2, '0, 8'h84, 0, "R7 pin high");
    @(negedge clk); wp_n = 0; @(negedge clk); wp_n = 1;
    chk_status("R8 after decision");
    pulse(2);
    set_sr(8'h00, "R7 disable gate");
    pulse(0); req(2, '0, 8'h08, 1, "R7 gate off pin low"); pulse(2);
  endtask

  task automatic t_idpage;
    set_sr(8'h40, "R9 select");
    pulse(0); req(1, 17'h00000, 8'h00, 0, "R9 open"); pulse(2);
    set_sr(8'h44, "R9 quarter");
    pulse(0);
    req(1, 17'h18005, 8'h00, 0, "R9 locked quarter");
    req(1, 17'h08000, 8'h00, 0, "R9 free quarter");
    pulse(2);
    pulse(3); chk_status("R11 access end");
    set_sr(8'h0C, "R9 full");
    pulse(0); req(1, 17'h00000, 8'h00, 0, "R9 full protect");
    req(2, '0, 8'h10, 0, "R10 set lock"); pulse(2);
    pulse(0); req(1, 17'h00000, 8'h00, 0, "R9 lock denies");
    req(2, '0, 8'h00, 0, "R10 clear attempt"); pulse(2);
    chk("R10 lock kept", {31'b0, status_byte[4]}, 32'd1);
  endtask

  task automatic t_busy;
    @(negedge clk); cyc_busy = 1;
    @(negedge clk); chk_status("R12 ready bit");
    pulse(0); chk_status("R12 wren ignored");
    req(0, 17'h00000, 8'h00, 0, "R12 frame ignored");
    @(negedge clk); cyc_busy = 0;
    pulse(0);
    @(negedge clk); cyc_busy = 1;
    pulse(1); chk_status("R12 wrdi ignored");
    pulse(2); chk_status("R2 done while busy");
    @(negedge clk); cyc_busy = 0;
  endtask

  initial begin
    t_reset();
    t_wel();
    t_ranges();
    t_wrsr_bits();
    t_wp();
    t_idpage();
    t_busy();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule